// File: doc/BRIEF.md
# Byte-Port Priority Interrupt Controller

This block gathers eight interrupt request lines, ranks them with a fixed order in which input 0 wins and input 7 loses, and raises one interrupt line toward a processor. Software talks to it through two byte-wide register addresses. Address 0 takes commands and returns a status byte. Address 1 takes the setup bytes and, once setup is done, holds the mask. After reset the block stays silent until software has written a start command and the setup bytes that the start command asks for.

When the processor answers with an acknowledge pulse, the block returns an 8-bit vector: the programmed base plus the index of the winning input. It marks that input as in service and drops its pending bit. Software then ends the service with an end-of-interrupt command, which retires the in-service bit of highest rank. A request line is latched on its rising edge and stays pending only while the line stays high. If the line falls before the acknowledge, there is no request to answer. The block then returns the vector of input 7 and leaves the in-service register untouched, so software can tell that the interrupt was spurious.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the pending, in-service and mask registers are all zero, int_req is low, and a read of address 0 returns the pending register.
- R2: A write to address 0 with bit 4 set starts setup. Bit 1 = 0 asks for a cascade byte and bit 0 = 1 asks for a mode byte, so 0x11 asks for both. The following address-1 writes load, in order, the vector base, the cascade byte (cfg_casc) and the mode byte (cfg_mode). int_req stays low until the last of these writes.
- R3: A start command with bit 1 set skips the cascade byte, which then reads as 0. A start command with bit 0 clear skips the mode byte, which then reads as 0.
- R4: Once running, an address-1 write loads the mask and an address-1 read returns it. A mask bit of 1 keeps that input from raising int_req, while its pending bit still latches.
- R5: A rising edge on an input sets its pending bit one clock later. The bit stays set while the input stays high. It clears when the input goes low or when the input is acknowledged.
- R6: int_req is high when some unmasked pending input has a lower index than every in-service input. Index 0 has the highest rank.
- R7: An acknowledge returns vector = (base + index) mod 256 for the winning input, sets that input's in-service bit and clears its pending bit.
- R8: An acknowledge with no qualifying request returns (base + 7) mod 256 and leaves the in-service register unchanged.
- R9: While running, an address-0 write with bits 4:3 = 01 and bit 1 set selects the read source of address 0: bit 0 = 0 selects the pending register, bit 0 = 1 the in-service register (0x0A and 0x0B).
- R10: Writing 0x20 to address 0 clears the lowest-index set bit of the in-service register. If that register is empty, the write has no effect.
- R11: A new start command issued while running clears the mask, the in-service and pending registers and the read select, and holds int_req low until setup is complete again.
- R12: An acknowledge before setup is complete changes neither the in-service nor the pending register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register address (0 command/status, 1 setup/mask) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register (combinational) |
| irq_in | input | 8 | Request lines, index 0 highest rank |
| int_req | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | One-cycle acknowledge from the processor |
| vec_out | output | 8 | Vector, valid while int_ack is high |
| cfg_casc | output | 8 | Stored cascade configuration byte |
| cfg_mode | output | 8 | Stored mode byte |

## Verification
The assertions assume that an acknowledge and an end-of-interrupt command never fall in the same cycle. They also assume that int_ack is a single-cycle pulse and that nothing arrives on the bus between the steps of setup that the check does not expect. The bench keeps to these limits. It issues bus writes and acknowledges from one sequential thread, always a full cycle apart, and changes request lines only on falling clock edges. Where two requests must compete, it raises them in the same cycle.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int PIC_N  = 8;
  localparam int PIC_IW = $clog2(PIC_N);

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_BASE = 3'd1,
    ST_CASC = 3'd2,
    ST_MODE = 3'd3,
    ST_RUN  = 3'd4
  } seq_state_t;

  // Lowest set index of a request vector; PIC_N when nothing is set.
  function automatic logic [PIC_IW:0] lowest_idx(input logic [PIC_N-1:0] v);
    logic [PIC_IW:0] r;
    r = PIC_IW'(0) + (PIC_IW+1)'(PIC_N);
    for (int k = PIC_N - 1; k >= 0; k--) begin
      if (v[k]) r = (PIC_IW+1)'(k);
    end
    return r;
  endfunction

  // One-hot bit for an index; zero when index is out of range.
  function automatic logic [PIC_N-1:0] idx_bit(input logic [PIC_IW:0] idx);
    logic [PIC_N-1:0] r;
    r = '0;
    for (int k = 0; k < PIC_N; k++) begin
      if (idx == (PIC_IW+1)'(k)) r[k] = 1'b1;
    end
    return r;
  endfunction

  // Vector = base + index, wrapping at 8 bits.
  function automatic logic [7:0] vec_calc(input logic [7:0] base, input logic [PIC_IW-1:0] idx);
    return base + {{(8-PIC_IW){1'b0}}, idx};
  endfunction
endpackage

// File: rtl/pic_cfg_seq.sv
module pic_cfg_seq
  import pic_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          reg_sel,
  input  logic [DW-1:0] wdata,
  output logic          ready,
  output logic [DW-1:0] base,
  output logic [DW-1:0] casc,
  output logic [DW-1:0] mode,
  output logic [DW-1:0] mask,
  output logic          sel_isr,
  output logic          eoi_evt,
  output logic          restart_evt
);
  seq_state_t st;
  logic need_casc, need_mode;
  logic cmd_wr, data_wr, ocw3_wr;

  assign cmd_wr      = wr_en && !reg_sel;
  assign data_wr     = wr_en && reg_sel;
  assign restart_evt = cmd_wr && wdata[4];
  assign ready       = (st == ST_RUN);
  assign eoi_evt     = cmd_wr && ready && (wdata[7:5] == 3'b001) && (wdata[4:3] == 2'b00);
  assign ocw3_wr     = cmd_wr && ready && (wdata[4:3] == 2'b01) && wdata[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      base      <= '0;
      casc      <= '0;
      mode      <= '0;
      mask      <= '0;
      sel_isr   <= 1'b0;
      need_casc <= 1'b0;
      need_mode <= 1'b0;
    end else if (restart_evt) begin
      st        <= ST_BASE;
      mask      <= '0;
      sel_isr   <= 1'b0;
      casc      <= '0;
      mode      <= '0;
      need_casc <= !wdata[1];
      need_mode <= wdata[0];
    end else if (ocw3_wr) begin
      sel_isr <= wdata[0];
    end else if (data_wr) begin
      unique case (st)
        ST_BASE: begin
          base <= wdata;
          st   <= need_casc ? ST_CASC : (need_mode ? ST_MODE : ST_RUN);
        end
        ST_CASC: begin
          casc <= wdata;
          st   <= need_mode ? ST_MODE : ST_RUN;
        end
        ST_MODE: begin
          mode <= wdata;
          st   <= ST_RUN;
        end
        ST_RUN:  mask <= wdata;
        default: ;
      endcase
    end
  end

  // Start command wipes the mask and leaves the block not ready
  p_restart_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    restart_evt |=> (mask == '0) && !ready && !sel_isr);
  // Cascade byte slot is only entered from the base slot
  p_casc_after_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CASC) |-> ($past(st) == ST_BASE || $past(st) == ST_CASC));
  // Mask never changes outside of running state except through restart
  p_mask_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ready) && !$past(restart_evt)) |-> $stable(mask));
endmodule

// File: rtl/pic_req_latch.sv
module pic_req_latch
  import pic_pkg::*;
#(
  parameter int N = PIC_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_in,
  input  logic [N-1:0] ack_clr,
  input  logic         restart_evt,
  output logic [N-1:0] irr
);
  logic [N-1:0] irq_q;
  logic [N-1:0] rise;

  assign rise = irq_in & ~irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= '0;
      irr   <= '0;
    end else begin
      irq_q <= irq_in;
      if (restart_evt) irr <= '0;
      else             irr <= (irr | rise) & irq_in & ~ack_clr;
    end
  end

  // A pending bit exists only for a line that was high at the last edge
  p_irr_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irr & ~$past(irq_in)) == '0);
  // An acknowledged line leaves the pending register
  p_ack_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_clr != '0) |=> ((irr & $past(ack_clr)) == '0));
endmodule

// File: rtl/pic_service.sv
module pic_service
  import pic_pkg::*;
#(
  parameter int N  = PIC_N,
  parameter int IW = PIC_IW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ready,
  input  logic [N-1:0] irr,
  input  logic [N-1:0] mask,
  input  logic [7:0]   base,
  input  logic         int_ack,
  input  logic         eoi_evt,
  input  logic         restart_evt,
  output logic [N-1:0] isr,
  output logic [N-1:0] ack_clr,
  output logic         int_req,
  output logic [7:0]   vec_out
);
  logic [IW:0]   cand, top;
  logic          qual, take, spur;
  logic [N-1:0]  eoi_clr;
  logic [IW-1:0] win_idx;

  assign cand    = lowest_idx(irr & ~mask);
  assign top     = lowest_idx(isr);
  assign qual    = ready && !cand[IW] && (cand < top);
  assign int_req = qual;
  assign take    = int_ack && qual;
  assign spur    = int_ack && ready && !qual;
  assign win_idx = qual ? cand[IW-1:0] : IW'(N - 1);
  assign vec_out = vec_calc(base, win_idx);
  assign ack_clr = take ? idx_bit(cand) : '0;
  assign eoi_clr = eoi_evt ? idx_bit(top) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)           isr <= '0;
    else if (restart_evt) isr <= '0;
    else                  isr <= (isr & ~eoi_clr) | ack_clr;
  end

  // The served input shows up in service on the next cycle
  p_take_marks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !eoi_evt && !restart_evt) |=> isr[$past(win_idx)]);
  // A spurious acknowledge leaves the in-service register alone
  p_spur_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (spur && !eoi_evt && !restart_evt) |=> $stable(isr));
  // End of interrupt retires exactly one bit
  p_eoi_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_evt && !int_ack && !restart_evt && isr != '0) |=>
      ($countones(isr) == $countones($past(isr)) - 1));
  // Acknowledge before setup has no effect
  p_idle_ack_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && !ready && !restart_evt) |=> $stable(isr));
  // At most one in-service bit is added per cycle
  p_one_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_clr));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       reg_sel,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] irq_in,
  output logic       int_req,
  input  logic       int_ack,
  output logic [7:0] vec_out,
  output logic [7:0] cfg_casc,
  output logic [7:0] cfg_mode
);
  logic       ready, sel_isr, eoi_evt, restart_evt;
  logic [7:0] base, mask, irr, isr, ack_clr;

  pic_cfg_seq #(.DW(8)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel), .wdata(wdata),
    .ready(ready), .base(base), .casc(cfg_casc), .mode(cfg_mode), .mask(mask),
    .sel_isr(sel_isr), .eoi_evt(eoi_evt), .restart_evt(restart_evt)
  );

  pic_req_latch #(.N(PIC_N)) u_irr (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ack_clr(ack_clr),
    .restart_evt(restart_evt), .irr(irr)
  );

  pic_service #(.N(PIC_N), .IW(PIC_IW)) u_svc (
    .clk(clk), .rst_n(rst_n), .ready(ready), .irr(irr), .mask(mask), .base(base),
    .int_ack(int_ack), .eoi_evt(eoi_evt), .restart_evt(restart_evt),
    .isr(isr), .ack_clr(ack_clr), .int_req(int_req), .vec_out(vec_out)
  );

  assign rdata = reg_sel ? mask : (sel_isr ? isr : irr);

  // Request is never raised before setup completes
  p_quiet_until_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_evt || $past(restart_evt)) |-> !int_req);
endmodule

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       reg_sel = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] irq_in = '0;
  logic       int_req;
  logic       int_ack = 1'b0;
  logic [7:0] vec_out;
  logic [7:0] cfg_casc, cfg_mode;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel), .wdata(wdata),
    .rdata(rdata), .irq_in(irq_in), .int_req(int_req), .int_ack(int_ack),
    .vec_out(vec_out), .cfg_casc(cfg_casc), .cfg_mode(cfg_mode)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung (act=%0d cycles, exp<100000)", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; reg_sel = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    reg_sel = a;
    #1 d = rdata;
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(negedge clk);
    irq_in = v;
    @(negedge clk);
    #1;
  endtask

  task automatic ack(output logic [7:0] v);
    @(negedge clk);
    int_ack = 1'b1;
    #1 v = vec_out;
    @(negedge clk);
    int_ack = 1'b0;
  endtask

  task automatic rd_isr(output logic [7:0] d);
    wr(1'b0, 8'h0B);
    rd(1'b0, d);
    wr(1'b0, 8'h0A);
  endtask

  logic [7:0] r, v, base_v;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 int_req", {7'b0, int_req}, 8'h00);
    rd(1'b0, r); check("R1 irr read", r, 8'h00);
    rd(1'b1, r); check("R1 mask read", r, 8'h00);

    // R12 / R5: request before setup latches but is not served
    set_irq(8'h08);
    check("R2 no req before setup", {7'b0, int_req}, 8'h00);
    rd(1'b0, r); check("R5 pending latched", r, 8'h08);
    ack(v);
    rd(1'b0, r); check("R12 ack idle keeps irr", r, 8'h08);
    set_irq(8'h00);
    rd(1'b0, r); check("R5 fall clears", r, 8'h00);

    // R2 full setup
    base_v = 8'h40;
    wr(1'b0, 8'h11);
    wr(1'b1, base_v);
    set_irq(8'h01);
    check("R2 held low mid setup", {7'b0, int_req}, 8'h00);
    set_irq(8'h00);
    wr(1'b1, 8'h04);
    wr(1'b1, 8'h01);
    check("R2 casc byte", cfg_casc, 8'h04);
    check("R2 mode byte", cfg_mode, 8'h01);

    // R4 mask sweep
    for (int m = 0; m < 256; m++) begin
      wr(1'b1, 8'(m));
      rd(1'b1, r); check("R4 mask readback", r, 8'(m));
    end
    wr(1'b1, 8'h00);

    // R5 R6 R7 R9 R10 single input sweep
    for (int i = 0; i < 8; i++) begin
      set_irq(8'(1 << i));
      check("R6 single req", {7'b0, int_req}, 8'h01);
      rd(1'b0, r); check("R5 irr bit", r, 8'(1 << i));
      ack(v); check("R7 vector", v, 8'(base_v + i));
      #1 check("R6 req drops after ack", {7'b0, int_req}, 8'h00);
      rd(1'b0, r); check("R7 irr cleared", r, 8'h00);
      rd_isr(r); check("R9 isr select", r, 8'(1 << i));
      wr(1'b0, 8'h20);
      rd_isr(r); check("R10 eoi clears", r, 8'h00);
      set_irq(8'h00);
    end

    // R6 R7 pairwise priority
    for (int i = 0; i < 8; i++) begin
      for (int j = i + 1; j < 8; j++) begin
        set_irq(8'((1 << i) | (1 << j)));
        ack(v); check("R6 winner lower index", v, 8'(base_v + i));
        #1 check("R6 lower rank blocked", {7'b0, int_req}, 8'h00);
        wr(1'b0, 8'h20);
        #1 check("R6 lower rank after eoi", {7'b0, int_req}, 8'h01);
        ack(v); check("R7 second vector", v, 8'(base_v + j));
        wr(1'b0, 8'h20);
        set_irq(8'h00);
      end
    end

    // R6 R10 nesting
    set_irq(8'h20);
    ack(v); check("R7 nest outer", v, 8'(base_v + 5));
    set_irq(8'h22);
    check("R6 higher preempts", {7'b0, int_req}, 8'h01);
    ack(v); check("R7 nest inner", v, 8'(base_v + 1));
    rd_isr(r); check("R7 both in service", r, 8'h22);
    wr(1'b0, 8'h20);
    rd_isr(r); check("R10 highest retired first", r, 8'h20);
    wr(1'b0, 8'h20);
    rd_isr(r); check("R10 second retire", r, 8'h00);
    wr(1'b0, 8'h20);
    rd_isr(r); check("R10 empty eoi no effect", r, 8'h00);
    set_irq(8'h00);

    // R4 masked input latches but does not raise
    wr(1'b1, 8'h08);
    set_irq(8'h08);
    check("R4 masked no req", {7'b0, int_req}, 8'h00);
    rd(1'b0, r); check("R4 masked pending", r, 8'h08);
    wr(1'b1, 8'h00);
    #1 check("R4 unmask raises", {7'b0, int_req}, 8'h01);
    ack(v); check("R7 after unmask", v, 8'(base_v + 3));
    wr(1'b0, 8'h20);
    set_irq(8'h00);

    // R8 spurious
    set_irq(8'h10);
    check("R8 req seen", {7'b0, int_req}, 8'h01);
    set_irq(8'h00);
    ack(v); check("R8 spurious vector", v, 8'(base_v + 7));
    rd_isr(r); check("R8 isr untouched", r, 8'h00);

    // R11 restart while running, R3 short setup
    set_irq(8'h40);
    ack(v);
    wr(1'b1, 8'h80);
    wr(1'b0, 8'h0B);
    set_irq(8'h00);
    wr(1'b0, 8'h12);
    rd(1'b1, r); check("R11 mask cleared", r, 8'h00);
    rd(1'b0, r); check("R11 select back to irr", r, 8'h00);
    set_irq(8'h04);
    check("R11 held low", {7'b0, int_req}, 8'h00);
    set_irq(8'h00);
    base_v = 8'hF9;
    wr(1'b1, base_v);
    check("R3 no casc byte", cfg_casc, 8'h00);
    check("R3 no mode byte", cfg_mode, 8'h00);
    rd_isr(r); check("R11 isr cleared", r, 8'h00);
    set_irq(8'h80);
    check("R3 running after base", {7'b0, int_req}, 8'h01);
    ack(v); check("R7 vector wraps", v, 8'h00);
    wr(1'b0, 8'h20);
    set_irq(8'h00);
    set_irq(8'h04);
    set_irq(8'h00);
    ack(v); check("R8 spurious wraps", v, 8'h00);

    // R3 single mode with mode byte
    wr(1'b0, 8'h13);
    wr(1'b1, 8'h20);
    check("R3 waiting for mode", {7'b0, int_req}, 8'h00);
    wr(1'b1, 8'h01);
    check("R3 mode stored", cfg_mode, 8'h01);
    check("R3 casc skipped", cfg_casc, 8'h00);
    set_irq(8'h02);
    ack(v); check("R7 new base", v, 8'h21);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule